// File: doc/BRIEF.md
# Transmit Gain Index Calculator

This block converts a requested transmit power into a row number of a gain table whose rows are half-dB apart, where a larger row number means lower gain. All power inputs use half-dBm units. The block first picks a saturation ceiling. This is the calibrated peak level, or a per-band default when the calibrated level lies outside its allowed window. It then caps the requested power at the lower of that ceiling and the regulatory ceiling.

The distance from the ceiling down to the capped power is added to a calibration reference row. That reference row is the table row that produces the saturation level. Fixed backoff steps are added next: one set for multi-antenna operation and one for CCK on revision B silicon. A further offset is added for the 5 GHz table, because that table extends into negative indexes.

The result is held to the table's last row. It appears one clock after the request strobe, with a flag that reports any limiting.

Top module: `txg_index_calc`

## Requirements
- R1: A result strobe `res_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise; back-to-back requests give back-to-back results.
- R2: The effective power is the lowest of the target, the regulatory limit and the saturation ceiling. The base index is `req_cal_idx + (ceiling - effective power)`.
- R3: When `req_sat_cal` is below SAT_MIN (20) or above SAT_MAX (50), the ceiling is a default of 38 for band 0 (2.4 GHz) or 36 for band 1 (5 GHz). Inside the window, the calibrated value is used.
- R4: With `req_mimo` high, 6 steps (3 dB) are added to the index.
- R5: With `req_cck` high and revision field `req_hw_rev[3:2]` equal to 1 (revision B), 9 steps are added. Revision 2 (C) and OFDM requests get no CCK backoff.
- R6: Band 1 (5 GHz) adds an offset of 9 to the index.
- R7: An index above IDX_MAX (200) is replaced by IDX_MAX. `res_clamped` is high when the target was limited by either ceiling or the index was saturated. It is low otherwise, including for an index of exactly IDX_MAX.
- R8: While `rst_n` is low at a clock edge, `res_valid`, `res_idx` and `res_clamped` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_target | input | 8 | Requested power, half-dBm |
| req_reg_limit | input | 8 | Regulatory ceiling, half-dBm |
| req_sat_cal | input | 8 | Calibrated saturation level, half-dBm |
| req_band | input | 1 | 0 = 2.4 GHz, 1 = 5 GHz |
| req_cck | input | 1 | 1 = CCK, 0 = OFDM |
| req_mimo | input | 1 | Multi-antenna transmission |
| req_cal_idx | input | 8 | Table row giving the saturation level |
| req_hw_rev | input | 8 | Hardware revision word, class in bits [3:2] |
| res_valid | output | 1 | Result strobe |
| res_idx | output | 8 | Gain table index |
| res_clamped | output | 1 | Target or index was limited |

## Verification
On every cycle, the assertions check the one-cycle strobe relation, the bound on the output index, and that the effective power never exceeds either ceiling. They also check that the total backoff never exceeds the sum of all fixed steps. Only the bench scenarios can show the exact arithmetic. This covers the choice between default and calibrated saturation at the window edges, the revision decode, and the per-band offset. It also covers the boundary between an index of exactly IDX_MAX, which is not flagged, and one that overflows and is flagged.

// File: rtl/txg_pkg.sv
// Shared constants for the transmit gain index calculator.
// Assumes: half-dB table steps, revision class held in a 2-bit field.
package txg_pkg;
    localparam int unsigned STEP_W       = 5;
    localparam int unsigned MIMO_STEPS   = 6;
    localparam int unsigned CCK_B_STEPS  = 9;
    localparam int unsigned BAND5_OFFSET = 9;
    localparam logic [1:0]  REV_CLASS_B  = 2'd1;
    localparam logic [1:0]  REV_CLASS_C  = 2'd2;

    typedef enum logic {
        BAND_24 = 1'b0,
        BAND_5  = 1'b1
    } band_e;
endpackage

// File: rtl/txg_limit.sv
// Ceiling selection: picks the saturation ceiling (calibrated or default)
// and caps the requested power at the lower of both ceilings.
// Assumes: all power values are unsigned half-dBm.
module txg_limit #(
    parameter int unsigned PW         = 8,
    parameter int unsigned SAT_MIN    = 20,
    parameter int unsigned SAT_MAX    = 50,
    parameter int unsigned SAT_DEF_24 = 38,
    parameter int unsigned SAT_DEF_52 = 36
) (
    input  logic [PW-1:0] target,
    input  logic [PW-1:0] reg_limit,
    input  logic [PW-1:0] sat_cal,
    input  logic          band,
    output logic [PW-1:0] eff_pwr,
    output logic [PW-1:0] headroom,
    output logic          tgt_limited
);
    import txg_pkg::*;

    logic [PW-1:0] sat_used;
    logic [PW-1:0] ceil_low;
    logic          cal_ok;

    // Choose the saturation ceiling: calibrated if within window, else band default.
    always_comb begin
        cal_ok = (sat_cal >= PW'(SAT_MIN)) && (sat_cal <= PW'(SAT_MAX));
        if (cal_ok)
            sat_used = sat_cal;
        else if (band == BAND_5)
            sat_used = PW'(SAT_DEF_52);
        else
            sat_used = PW'(SAT_DEF_24);
    end

    // Cap the target at the lower ceiling and measure distance below saturation.
    always_comb begin
        ceil_low    = (reg_limit < sat_used) ? reg_limit : sat_used;
        tgt_limited = target > ceil_low;
        eff_pwr     = tgt_limited ? ceil_low : target;
        headroom    = sat_used - eff_pwr;
    end

    // Guard both ceilings.
    always_comb begin
        a_r2_under_reg: assert (eff_pwr <= reg_limit)
            else $error("R2: effective power above regulatory limit");
        a_r2_under_sat: assert (eff_pwr <= sat_used)
            else $error("R2: effective power above saturation ceiling");
    end
endmodule

// File: rtl/txg_backoff.sv
// Fixed backoff steps: multi-antenna split, CCK revision-B backoff and
// the 5 GHz table offset, summed into one step count.
// Assumes: revision class sits in bits [3:2] of the revision word.
module txg_backoff #(
    parameter int unsigned REV_W = 8
) (
    input  logic                        band,
    input  logic                        cck,
    input  logic                        mimo,
    input  logic [REV_W-1:0]            hw_rev,
    output logic [txg_pkg::STEP_W-1:0]  steps
);
    import txg_pkg::*;

    logic rev_b;

    // Sum the step contributions that apply to this request.
    always_comb begin
        rev_b = (hw_rev[3:2] == REV_CLASS_B);
        steps = '0;
        if (mimo)
            steps = steps + STEP_W'(MIMO_STEPS);
        if (cck && rev_b)
            steps = steps + STEP_W'(CCK_B_STEPS);
        if (band == BAND_5)
            steps = steps + STEP_W'(BAND5_OFFSET);
    end

    // The step count never exceeds all contributions together.
    always_comb begin
        a_r5_step_total: assert (steps <= STEP_W'(MIMO_STEPS + CCK_B_STEPS + BAND5_OFFSET))
            else $error("R5: backoff step total out of range");
    end
endmodule

// File: rtl/txg_index_calc.sv
// Transmit gain index calculator top: combines the ceiling stage and the
// backoff stage, saturates the index to the table end and registers the
// result one cycle after each request strobe.
// Assumes: synchronous active-low reset, one request per strobe cycle.
module txg_index_calc #(
    parameter int unsigned PW         = 8,
    parameter int unsigned IW         = 8,
    parameter int unsigned REV_W      = 8,
    parameter int unsigned IDX_MAX    = 200,
    parameter int unsigned SAT_MIN    = 20,
    parameter int unsigned SAT_MAX    = 50,
    parameter int unsigned SAT_DEF_24 = 38,
    parameter int unsigned SAT_DEF_52 = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PW-1:0]    req_target,
    input  logic [PW-1:0]    req_reg_limit,
    input  logic [PW-1:0]    req_sat_cal,
    input  logic             req_band,
    input  logic             req_cck,
    input  logic             req_mimo,
    input  logic [IW-1:0]    req_cal_idx,
    input  logic [REV_W-1:0] req_hw_rev,
    output logic             res_valid,
    output logic [IW-1:0]    res_idx,
    output logic             res_clamped
);
    import txg_pkg::*;

    localparam int unsigned SUM_W = ((PW > IW) ? PW : IW) + 2;

    logic [PW-1:0]     eff_pwr;
    logic [PW-1:0]     headroom;
    logic              tgt_limited;
    logic [STEP_W-1:0] steps;
    logic [SUM_W-1:0]  raw_idx;
    logic              idx_over;
    logic [IW-1:0]     idx_next;

    txg_limit #(
        .PW(PW), .SAT_MIN(SAT_MIN), .SAT_MAX(SAT_MAX),
        .SAT_DEF_24(SAT_DEF_24), .SAT_DEF_52(SAT_DEF_52)
    ) limit_i (
        .target(req_target), .reg_limit(req_reg_limit), .sat_cal(req_sat_cal),
        .band(req_band), .eff_pwr(eff_pwr), .headroom(headroom),
        .tgt_limited(tgt_limited)
    );

    txg_backoff #(.REV_W(REV_W)) backoff_i (
        .band(req_band), .cck(req_cck), .mimo(req_mimo),
        .hw_rev(req_hw_rev), .steps(steps)
    );

    // Add reference row, headroom and backoff, then saturate at the table end.
    always_comb begin
        raw_idx  = SUM_W'(req_cal_idx) + SUM_W'(headroom) + SUM_W'(steps);
        idx_over = raw_idx > SUM_W'(IDX_MAX);
        idx_next = idx_over ? IW'(IDX_MAX) : raw_idx[IW-1:0];
    end

    // Register the result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_idx     <= '0;
            res_clamped <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_idx     <= idx_next;
                res_clamped <= tgt_limited || idx_over;
            end
        end
    end

    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid)
        else $error("R1: missing result after request");

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid)
        else $error("R1: result without request");

    a_r7_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_idx <= IW'(IDX_MAX)))
        else $error("R7: index beyond table end");
endmodule

// File: tb/txg_index_calc_tb_top.sv
module txg_index_calc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_target = '0, req_reg_limit = '0, req_sat_cal = '0;
    logic       req_band = 1'b0, req_cck = 1'b0, req_mimo = 1'b0;
    logic [7:0] req_cal_idx = '0, req_hw_rev = '0;
    logic       res_valid;
    logic [7:0] res_idx;
    logic       res_clamped;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txg_index_calc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_target(req_target), .req_reg_limit(req_reg_limit),
        .req_sat_cal(req_sat_cal), .req_band(req_band), .req_cck(req_cck),
        .req_mimo(req_mimo), .req_cal_idx(req_cal_idx), .req_hw_rev(req_hw_rev),
        .res_valid(res_valid), .res_idx(res_idx), .res_clamped(res_clamped)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Independent reference model built from the requirements.
    function automatic void model(input int tgt, reg_l, sat, band, cck, mimo,
                                  cal, rev, output int idx, output int clamp);
        int ceil_s, low, eff, sum;
        ceil_s = (sat < 20 || sat > 50) ? (band ? 36 : 38) : sat;
        low    = (reg_l < ceil_s) ? reg_l : ceil_s;
        eff    = (tgt > low) ? low : tgt;
        sum    = cal + (ceil_s - eff);
        if (mimo) sum += 6;
        if (cck && ((rev >> 2) & 3) == 1) sum += 9;
        if (band) sum += 9;
        clamp = (tgt > low) || (sum > 200);
        idx   = (sum > 200) ? 200 : sum;
    endfunction

    task automatic drive(input int tgt, reg_l, sat, band, cck, mimo, cal, rev);
        req_valid = 1'b1; req_target = 8'(tgt); req_reg_limit = 8'(reg_l);
        req_sat_cal = 8'(sat); req_band = band[0]; req_cck = cck[0];
        req_mimo = mimo[0]; req_cal_idx = 8'(cal); req_hw_rev = 8'(rev);
    endtask

    // One request; the result is sampled at the following negedge.
    task automatic one_req(input string tag, input int tgt, reg_l, sat, band,
                           cck, mimo, cal, rev);
        int ei, ec;
        model(tgt, reg_l, sat, band, cck, mimo, cal, rev, ei, ec);
        @(negedge clk);
        drive(tgt, reg_l, sat, band, cck, mimo, cal, rev);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, int'(res_valid), 1);
        check({tag, " idx"}, int'(res_idx), ei);
        check({tag, " clamp"}, int'(res_clamped), ec);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 valid", int'(res_valid), 0);
        check("R8 idx", int'(res_idx), 0);
        check("R8 clamp", int'(res_clamped), 0);
    endtask

    task automatic t_ceilings();
        one_req("R2 unlimited", 30, 34, 40, 0, 0, 0, 20, 0);
        one_req("R2 reg-limited", 40, 32, 44, 0, 0, 0, 20, 0);
        one_req("R2 sat-limited", 45, 48, 42, 0, 0, 0, 20, 0);
    endtask

    task automatic t_default_sat();
        one_req("R3 high 2.4", 30, 40, 60, 0, 0, 0, 10, 0);
        one_req("R3 low 5", 30, 40, 10, 1, 0, 0, 10, 0);
        one_req("R3 edge min", 30, 40, 20, 0, 0, 0, 10, 0);
        one_req("R3 edge max", 30, 60, 50, 0, 0, 0, 10, 0);
        one_req("R3 above max", 30, 60, 51, 0, 0, 0, 10, 0);
    endtask

    task automatic t_mimo();
        one_req("R4 mimo", 30, 40, 40, 0, 0, 1, 20, 0);
    endtask

    task automatic t_cck();
        one_req("R5 cck revB", 30, 40, 40, 0, 1, 0, 20, 8'h04);
        one_req("R5 cck revC", 30, 40, 40, 0, 1, 0, 20, 8'h08);
        one_req("R5 ofdm revB", 30, 40, 40, 0, 0, 0, 20, 8'h04);
        one_req("R5 all steps", 30, 40, 40, 1, 1, 1, 20, 8'hF4);
    endtask

    task automatic t_band5();
        one_req("R6 band5", 30, 40, 40, 1, 0, 0, 20, 0);
    endtask

    task automatic t_saturate();
        one_req("R7 exact max", 20, 40, 40, 0, 0, 0, 180, 0);
        one_req("R7 overflow", 20, 40, 40, 0, 0, 0, 195, 0);
        one_req("R7 big overflow", 0, 40, 50, 1, 1, 1, 255, 8'h04);
    endtask

    task automatic t_pipeline();
        int e0, c0, e1, c1;
        model(30, 40, 40, 0, 0, 0, 5, 0, e0, c0);
        model(25, 40, 40, 1, 0, 1, 7, 0, e1, c1);
        @(negedge clk);
        drive(30, 40, 40, 0, 0, 0, 5, 0);
        @(negedge clk);
        check("R1 b2b first valid", int'(res_valid), 1);
        check("R1 b2b first idx", int'(res_idx), e0);
        drive(25, 40, 40, 1, 0, 1, 7, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 b2b second valid", int'(res_valid), 1);
        check("R1 b2b second idx", int'(res_idx), e1);
        @(negedge clk);
        check("R1 idle no valid", int'(res_valid), 0);
        @(negedge clk);
        check("R1 idle still no valid", int'(res_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ceilings();
        t_default_sat();
        t_mimo();
        t_cck();
        t_band5();
        t_saturate();
        t_pipeline();
        // R8: reset mid-run clears the outputs.
        @(negedge clk);
        drive(30, 40, 40, 0, 0, 0, 20, 0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        t_reset();
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule